// File: doc/BRIEF.md
# Breakpoint Tag Lookup Unit

This block watches a bus value, such as an instruction fetch address or a data address, together with a valid strobe. The full bus value indexes a tag table. Each table entry holds one bit per breakpoint. A breakpoint fires for every bus value whose bit is set in the table. A breakpoint can therefore cover one value, a contiguous range, or any scattered set of values. What the table holds decides this, not any comparator logic.

Each breakpoint has a 2-bit action selector:
- `00`: off.
- `01`: pulse a counter event.
- `10`: request a processor halt.
- `11`: AND the breakpoint with its upper neighbour (modulo the breakpoint count) and report the result on a chained-hit output.

A host port writes, clears and reads back table entries. While it is selected, the watched bus is ignored. In coverage mode, each qualified bus value ORs the bits of all non-off breakpoints into its own entry. The table then gathers a map of every value seen.

The table lookup is a single registered stage, so events appear one cycle after the bus value is presented. After reset, a sequential sweep zeroes every entry and holds `busy` high until it is done. The intended deployment uses a 16-bit bus (65536 entries) and 8 breakpoints. The bus width is a parameter.

Top module: `bp_tag_unit`

## Requirements
- R1: After reset `busy` is 1. It falls after exactly 2^ADDR_W clock cycles and then stays 0. Every table entry reads 0 afterwards. While `busy` is 1, no event, halt or chained-hit output is raised.
- R2: A host cycle with `host_sel`=1 and `host_we`=1 stores `host_wdata` at `host_addr`. A host cycle with `host_sel`=1 and `host_we`=0 returns the entry at `host_addr` on `host_rdata` one cycle later.
- R3: A qualified bus value V presented in cycle n raises outputs in cycle n+1 for each breakpoint i whose bit i is 1 in entry V. Single values, ranges and scattered sets all behave this way.
- R4: A breakpoint with action `00` (bits [2i+1:2i] of `act_cfg`) drives no output.
- R5: A breakpoint with action `01` that hits raises `cnt_evt[i]` for one cycle.
- R6: A breakpoint with action `10` that hits raises `halt_req`.
- R7: A breakpoint with action `11` raises `comb_hit[i]` only if both bit i and bit (i+1) mod NBP of the entry are 1. For i=NBP-1 the partner is breakpoint 0.
- R8: With `bus_vld`=0, no output is raised and no coverage write happens.
- R9: With `host_sel`=1, the bus lookup is suppressed and no coverage write happens, so host writes always win.
- R10: With `cov_en`=1, a qualified bus value V ORs into entry V a 1 for every breakpoint whose action is not `00`. Bits of breakpoints set to `00` are left unchanged. The hit reported for that cycle uses the entry value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_val | input | ADDR_W | Watched bus value |
| bus_vld | input | 1 | Qualifies `bus_val` |
| host_sel | input | 1 | Host access this cycle |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | ADDR_W | Host table index |
| host_wdata | input | NBP | Host write data |
| host_rdata | output | NBP | Host read data, one cycle latency |
| act_cfg | input | 2*NBP | Action per breakpoint, 2 bits each |
| cov_en | input | 1 | Coverage recording enable |
| busy | output | 1 | Reset clear sweep in progress |
| halt_req | output | 1 | Halt request |
| cnt_evt | output | NBP | Counter event per breakpoint |
| comb_hit | output | NBP | Chained-condition result per breakpoint |

## Verification
The bench builds the unit with ADDR_W=6 and NBP=8. With these values the reset sweep lasts 64 cycles, and the bench can read back every entry to confirm that the sweep zeroed all of them. The full breakpoint count is kept, so the chained pair that wraps from breakpoint 7 to breakpoint 0 is exercised. Ranges, scattered sets and coverage accumulation all fit in a table small enough to inspect completely.

// File: rtl/bp_tag_unit.sv
module bp_tag_unit #(
  parameter int ADDR_W = 10,
  parameter int NBP    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_val,
  input  logic              bus_vld,
  input  logic              host_sel,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [NBP-1:0]    host_wdata,
  output logic [NBP-1:0]    host_rdata,
  input  logic [2*NBP-1:0]  act_cfg,
  input  logic              cov_en,
  output logic              busy,
  output logic              halt_req,
  output logic [NBP-1:0]    cnt_evt,
  output logic [NBP-1:0]    comb_hit
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [NBP-1:0]    tags [DEPTH];
  logic [ADDR_W-1:0] clr_idx;
  logic [NBP-1:0]    rd_q;
  logic              vld_q;
  logic [NBP-1:0]    live_mask;
  logic [NBP-1:0]    hit;
  logic [NBP-1:0]    stop_hit;

  wire look = bus_vld & ~host_sel & ~busy;
  wire hwr  = host_sel & host_we & ~busy;
  wire hrd  = host_sel & ~host_we & ~busy;

  always_ff @(posedge clk) begin
    if (busy)
      tags[clr_idx] <= '0;
    else if (hwr)
      tags[host_addr] <= host_wdata;
    else if (look && cov_en)
      tags[bus_val] <= tags[bus_val] | live_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b1;
      clr_idx    <= '0;
      vld_q      <= 1'b0;
      rd_q       <= '0;
      host_rdata <= '0;
    end else begin
      if (busy) begin
        clr_idx <= clr_idx + 1'b1;
        if (&clr_idx) busy <= 1'b0;
      end
      vld_q <= look;
      if (look) rd_q <= tags[bus_val];
      if (hrd)  host_rdata <= tags[host_addr];
    end
  end

  assign hit = rd_q & {NBP{vld_q}};

  for (genvar i = 0; i < NBP; i++) begin : g_bp
    wire [1:0] md = act_cfg[2*i +: 2];
    assign live_mask[i] = |md;
    assign cnt_evt[i]   = hit[i] & (md == 2'b01);
    assign stop_hit[i]  = hit[i] & (md == 2'b10);
    assign comb_hit[i]  = hit[i] & hit[(i+1) % NBP] & (md == 2'b11);
  end

  assign halt_req = |stop_hit;
endmodule

// File: rtl/bp_tag_unit_chk.sv
module bp_tag_unit_chk #(
  parameter int NBP = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_vld,
  input logic             host_sel,
  input logic             busy,
  input logic             halt_req,
  input logic [NBP-1:0]   cnt_evt,
  input logic [NBP-1:0]   comb_hit,
  input logic [2*NBP-1:0] act_cfg
);
  // R1
  busy_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy);

  // R8
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_vld || busy) |=> (!halt_req && cnt_evt == '0 && comb_hit == '0));

  // R9
  host_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel |=> (!halt_req && cnt_evt == '0 && comb_hit == '0));

  for (genvar i = 0; i < NBP; i++) begin : g_mode
    // R5
    cnt_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_evt[i] |-> act_cfg[2*i +: 2] == 2'b01);
    // R7
    comb_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      comb_hit[i] |-> act_cfg[2*i +: 2] == 2'b11);
  end
endmodule

bind bp_tag_unit bp_tag_unit_chk #(.NBP(NBP)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .host_sel(host_sel),
  .busy(busy), .halt_req(halt_req), .cnt_evt(cnt_evt),
  .comb_hit(comb_hit), .act_cfg(act_cfg)
);

// File: tb/tb_bp_tag_unit.sv
`timescale 1ns/1ps
module tb_bp_tag_unit;
  localparam int AW = 6;
  localparam int NB = 8;
  localparam int VW = AW + 2 + 2*NB;

  logic clk = 0;
  logic rst_n = 0;
  logic [AW-1:0] bus_val = '0, host_addr = '0;
  logic bus_vld = 0, host_sel = 0, host_we = 0, cov_en = 0;
  logic [NB-1:0] host_wdata = '0, host_rdata, cnt_evt, comb_hit;
  logic [2*NB-1:0] act_cfg = '0;
  logic busy, halt_req;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  bp_tag_unit #(.ADDR_W(AW), .NBP(NB)) dut (
    .clk(clk), .rst_n(rst_n), .bus_val(bus_val), .bus_vld(bus_vld),
    .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .act_cfg(act_cfg),
    .cov_en(cov_en), .busy(busy), .halt_req(halt_req),
    .cnt_evt(cnt_evt), .comb_hit(comb_hit)
  );

  // {bus, vld, halt, cnt, comb}; bp0 stop, bp1 count, bp2 combine, bp3 count
  localparam logic [VW-1:0] VEC [9] = '{
    {6'd5,  1'b1, 1'b1, 8'h00, 8'h00},  // R6 single value
    {6'd11, 1'b1, 1'b0, 8'h02, 8'h00},  // R5 inside range
    {6'd12, 1'b1, 1'b0, 8'h02, 8'h00},  // R3 range end
    {6'd13, 1'b1, 1'b0, 8'h00, 8'h00},  // R3 past range
    {6'd20, 1'b1, 1'b0, 8'h00, 8'h00},  // R7 partner bit clear
    {6'd30, 1'b1, 1'b0, 8'h08, 8'h04},  // R7 both bits set
    {6'd5,  1'b0, 1'b0, 8'h00, 8'h00},  // R8 not valid
    {6'd40, 1'b1, 1'b0, 8'h00, 8'h00},  // R4 bp4 off
    {6'd63, 1'b1, 1'b0, 8'h00, 8'h00}   // R3 empty entry
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic hwrite(input logic [AW-1:0] a, input logic [NB-1:0] d);
    host_sel = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 0; host_we = 0;
  endtask

  task automatic hread(input logic [AW-1:0] a, output logic [NB-1:0] d);
    host_sel = 1; host_we = 0; host_addr = a;
    @(negedge clk);
    d = host_rdata;
    host_sel = 0;
  endtask

  task automatic drive(input logic [AW-1:0] v, input logic vl);
    bus_val = v; bus_vld = vl;
    @(negedge clk);
    bus_vld = 0;
  endtask

  initial begin
    #(8ns * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [NB-1:0] rd;
    int nz;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy after reset", busy, 1);
    bus_val = 6'd5; bus_vld = 1;
    @(negedge clk);
    chk("R1 quiet while busy", {halt_req, cnt_evt, comb_hit}, 0);
    bus_vld = 0;
    repeat (61) @(negedge clk);
    chk("R1 busy before end", busy, 1);
    @(negedge clk);
    chk("R1 busy dropped", busy, 0);
    nz = 0;
    for (int a = 0; a < 64; a++) begin
      hread(AW'(a), rd);
      if (rd != 0) nz++;
    end
    chk("R1 all entries zero", nz, 0);
    chk("R1 busy stays low", busy, 0);

    hwrite(6'd5, 8'h01);
    for (int a = 10; a <= 12; a++) hwrite(AW'(a), 8'h02);
    hwrite(6'd20, 8'h04);
    hwrite(6'd30, 8'h0C);
    hwrite(6'd40, 8'h10);
    hread(6'd30, rd);
    chk("R2 readback", rd, 8'h0C);

    act_cfg = 16'h00_00 | {8'h00, 2'b01, 2'b11, 2'b01, 2'b10};
    for (int k = 0; k < 9; k++) begin
      logic [VW-1:0] v = VEC[k];
      drive(v[VW-1 -: AW], v[VW-AW-1]);
      chk("R3/R4/R5/R6/R7/R8 vector", {halt_req, cnt_evt, comb_hit},
          {v[2*NB], v[2*NB-1:0]});
    end

    // R9: host access suppresses the lookup
    bus_val = 6'd5; bus_vld = 1; host_sel = 1; host_we = 0; host_addr = 6'd0;
    @(negedge clk);
    host_sel = 0; bus_vld = 0;
    chk("R9 lookup suppressed", {halt_req, cnt_evt, comb_hit}, 0);

    // R7: wrap from bp7 to bp0
    act_cfg[15:14] = 2'b11;
    hwrite(6'd50, 8'h81);
    drive(6'd50, 1);
    chk("R7 wrap chain", {halt_req, comb_hit}, {1'b1, 8'h80});
    hwrite(6'd51, 8'h80);
    drive(6'd51, 1);
    chk("R7 wrap partner clear", comb_hit, 0);
    act_cfg[15:14] = 2'b00;

    // R10: coverage writes; mask is bp0..bp3
    cov_en = 1;
    drive(6'd33, 1);
    chk("R10 old value reported", {halt_req, cnt_evt}, 0);
    drive(6'd5, 1);
    chk("R10 hit from old entry", halt_req, 1);
    drive(6'd40, 1);
    drive(6'd35, 0);
    bus_val = 6'd36; bus_vld = 1; host_sel = 1; host_we = 1;
    host_addr = 6'd37; host_wdata = 8'h40;
    @(negedge clk);
    host_sel = 0; host_we = 0; bus_vld = 0;
    cov_en = 0;
    hread(6'd33, rd); chk("R10 coverage fill", rd, 8'h0F);
    hread(6'd5, rd);  chk("R10 coverage OR", rd, 8'h0F);
    hread(6'd40, rd); chk("R10 off bit kept", rd, 8'h1F);
    hread(6'd35, rd); chk("R8 no write when invalid", rd, 8'h00);
    hread(6'd36, rd); chk("R9 no coverage under host", rd, 8'h00);
    hread(6'd37, rd); chk("R2 host write wins", rd, 8'h40);
    drive(6'd34, 1);
    hread(6'd34, rd); chk("R10 off when cov_en low", rd, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule